// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is a shared on-chip scratchpad memory divided into word-interleaved banks. A single request carries one operation, either a read or a write, for a whole group of lanes. Each lane brings its own word address, its own write data and an enable bit. In each cycle every bank serves at most one distinct word. When several lanes point at different words in the same bank, those lanes are served over later cycles. The stall output stays high until every enabled lane has been served.

A lane's bank is the low bits of its word address, and its row is the high bits. Lanes that target the same word are served together, so a request in which every lane uses one address costs a single cycle. Each served lane raises its bit of a completion mask in the cycle after it is served. For a read, the lane's data is valid in that same cycle. Software that wants conflict-free column access pads its row pitch to one word more than the bank count.

Top module: `scratch_serializer`

## Requirements
- R1: With the default 32 banks of 32 words, a lane's bank is the word address modulo 32 (address bits [4:0]) and its row is the address divided by 32 (bits [9:5]), so consecutive words sit in consecutive banks.
- R2: A request is taken only at a clock edge where `req_valid_i` is high and `stall_o` is low. A request presented while `stall_o` is high is ignored and writes nothing.
- R3: `stall_o` is low after reset and low while idle. It goes high in the cycle after a request with at least one enabled lane is taken. If every enabled lane hits a different bank, it stays high for exactly one cycle.
- R4: When k distinct words fall in one bank, `stall_o` stays high for k cycles, where k is the largest such count over all banks. A stride of 2 words gives 2 cycles and a stride of 32 words gives 32 cycles.
- R5: All pending lanes that share one word address are served in the same cycle. A read in which every lane uses the same address completes in one cycle.
- R6: Within a bank, the pending lane with the lowest index decides which word that bank serves in the current cycle.
- R7: Each enabled lane raises its `rd_done_o` bit for exactly one cycle, the cycle after it is served. On a read, that lane's slice of `rd_data_o` holds the stored word in that same cycle.
- R8: A write stores each lane's data at its address. If several lanes write the same address, the data of the highest-indexed of those lanes is kept.
- R9: Disabled lanes are never served and never raise `rd_done_o`. A request with no lane enabled leaves `stall_o` low.
- R10: After reset, `rd_done_o` and `rd_data_o` are zero and every memory word reads as zero.
- R11: A column access with a stride of 33 words hits 32 different banks and completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read, for the whole request |
| lane_en_i | input | LANES | Per-lane enable |
| lane_addr_i | input | LANES*ADDR_W | Per-lane word address, lane l at bits [l*ADDR_W +: ADDR_W] |
| lane_wdata_i | input | LANES*DATA_W | Per-lane write data, lane l at bits [l*DATA_W +: DATA_W] |
| stall_o | output | 1 | High while any lane of the current request is unserved |
| rd_done_o | output | LANES | Per-lane completion pulse |
| rd_data_o | output | LANES*DATA_W | Per-lane read data, valid with its done bit |

## Verification
The bench drives inputs and samples outputs on the falling clock edge. A request driven at one falling edge is taken at the next rising edge, and `stall_o` is first due high at the falling edge after that. A lane served at a given rising edge has its done bit and read data due at the falling edge that follows. At every falling edge the behavioural model advances one serve step and compares the stall level, the full done mask and the read data of each completed lane. Each test also compares the number of stall cycles against the count the conflict degree predicts.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } scr_op_e;
endpackage

// File: rtl/bank_arbiter.sv
module bank_arbiter #(
  parameter int LANES   = 32,
  parameter int BANK_W  = 5,
  parameter int ROW_W   = 5,
  parameter int DATA_W  = 32,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]             pend_i,
  input  logic [LANES-1:0][BANK_W-1:0] lane_bank_i,
  input  logic [LANES-1:0][ROW_W-1:0]  lane_row_i,
  input  logic [LANES-1:0][DATA_W-1:0] lane_wdata_i,
  output logic [LANES-1:0]             grant_o,
  output logic                         active_o,
  output logic [ROW_W-1:0]             row_o,
  output logic [DATA_W-1:0]            wdata_o
);
  logic [LANES-1:0] in_bank;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      in_bank[l] = pend_i[l] && (lane_bank_i[l] == BANK_W'(BANK_ID));
  end

  // lowest pending lane picks the row
  always_comb begin
    active_o = 1'b0;
    row_o    = '0;
    for (int l = 0; l < LANES; l++) begin
      if (in_bank[l] && !active_o) begin
        active_o = 1'b1;
        row_o    = lane_row_i[l];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      grant_o[l] = in_bank[l] && (lane_row_i[l] == row_o);
  end

  // highest granted lane wins on write
  always_comb begin
    wdata_o = '0;
    for (int l = 0; l < LANES; l++)
      if (grant_o[l]) wdata_o = lane_wdata_i[l];
  end
endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < DEPTH; r++) mem_q[r] <= '0;
    end else if (we_i) begin
      mem_q[row_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[row_i];
endmodule

// File: rtl/scratch_serializer.sv
module scratch_serializer #(
  parameter int LANES      = 32,
  parameter int BANKS      = 32,
  parameter int BANK_DEPTH = 32,
  parameter int DATA_W     = 32,
  localparam int BANK_W    = $clog2(BANKS),
  localparam int ROW_W     = $clog2(BANK_DEPTH),
  localparam int ADDR_W    = BANK_W + ROW_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic                     req_we_i,
  input  logic [LANES-1:0]         lane_en_i,
  input  logic [LANES*ADDR_W-1:0]  lane_addr_i,
  input  logic [LANES*DATA_W-1:0]  lane_wdata_i,
  output logic                     stall_o,
  output logic [LANES-1:0]         rd_done_o,
  output logic [LANES*DATA_W-1:0]  rd_data_o
);
  import scratch_pkg::*;

  scr_op_e                      op_q;
  logic [LANES-1:0]             pend_q;
  logic [LANES-1:0][BANK_W-1:0] bank_q;
  logic [LANES-1:0][ROW_W-1:0]  row_q;
  logic [LANES-1:0][DATA_W-1:0] wdata_q;
  logic [LANES-1:0]             done_q;
  logic [LANES-1:0][DATA_W-1:0] rdata_q;

  logic [BANKS-1:0][LANES-1:0]  bank_grant;
  logic [BANKS-1:0]             bank_active;
  logic [BANKS-1:0][ROW_W-1:0]  bank_row;
  logic [BANKS-1:0][DATA_W-1:0] bank_wdata;
  logic [BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic [LANES-1:0]             grant_all;
  logic                         accept;

  assign stall_o = |pend_q;
  assign accept  = req_valid_i && !stall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_READ;
      pend_q  <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_q   <= req_we_i ? OP_WRITE : OP_READ;
      pend_q <= lane_en_i;
      for (int l = 0; l < LANES; l++) begin
        bank_q[l]  <= lane_addr_i[l*ADDR_W +: BANK_W];
        row_q[l]   <= lane_addr_i[l*ADDR_W+BANK_W +: ROW_W];
        wdata_q[l] <= lane_wdata_i[l*DATA_W +: DATA_W];
      end
    end else begin
      pend_q <= pend_q & ~grant_all;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    bank_arbiter #(
      .LANES(LANES), .BANK_W(BANK_W), .ROW_W(ROW_W),
      .DATA_W(DATA_W), .BANK_ID(b)
    ) u_arb (
      .pend_i      (pend_q),
      .lane_bank_i (bank_q),
      .lane_row_i  (row_q),
      .lane_wdata_i(wdata_q),
      .grant_o     (bank_grant[b]),
      .active_o    (bank_active[b]),
      .row_o       (bank_row[b]),
      .wdata_o     (bank_wdata[b])
    );

    bank_store #(
      .DEPTH(BANK_DEPTH), .DATA_W(DATA_W)
    ) u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (bank_active[b] && (op_q == OP_WRITE)),
      .row_i  (bank_row[b]),
      .wdata_i(bank_wdata[b]),
      .rdata_o(bank_rdata[b])
    );
  end

  always_comb begin
    grant_all = '0;
    for (int b = 0; b < BANKS; b++) grant_all |= bank_grant[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= grant_all;
      for (int l = 0; l < LANES; l++)
        if (grant_all[l] && (op_q == OP_READ)) rdata_q[l] <= bank_rdata[bank_q[l]];
    end
  end

  assign rd_done_o = done_q;
  assign rd_data_o = rdata_q;

  // R3
  serve_progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ($countones(pend_q) < $past($countones(pend_q))));

  // R2
  hold_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ($stable(row_q) && $stable(bank_q) && $stable(op_q)));

  // R7
  done_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |rd_done_o |-> ((rd_done_o & ~$past(pend_q)) == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |=> (rd_done_o == '0));
endmodule

// File: tb/scratch_serializer_tb.sv
module scratch_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int NB = 32;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int WORDS = 1024;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_we = 0;
  logic [NL-1:0]    lane_en = '0;
  logic [NL*AW-1:0] lane_addr = '0;
  logic [NL*DW-1:0] lane_wdata = '0;
  logic             stall;
  logic [NL-1:0]    done;
  logic [NL*DW-1:0] rdata;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int          a_addr [NL];
  bit          a_en   [NL];
  logic [31:0] a_wd   [NL];
  logic [31:0] mdl    [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  scratch_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .lane_en_i(lane_en), .lane_addr_i(lane_addr), .lane_wdata_i(lane_wdata),
    .stall_o(stall), .rd_done_o(done), .rd_data_o(rdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive_model_lanes(input bit we);
    req_we = we;
    for (int l = 0; l < NL; l++) begin
      lane_en[l] = a_en[l];
      lane_addr[l*AW +: AW] = AW'(a_addr[l]);
      lane_wdata[l*DW +: DW] = a_wd[l];
    end
  endtask

  task automatic run_req(input bit we, input string tag, input int exp_cycles,
                         input bit junk);
    bit          pend [NL];
    bit          served [NL];
    logic [31:0] exp_rd [NL];
    int          taken [NB];
    int          cycles;
    logic [NL-1:0] exp_mask;
    exp_mask = '0;
    @(negedge clk);
    req_valid = 1;
    drive_model_lanes(we);
    for (int l = 0; l < NL; l++) begin pend[l] = a_en[l]; exp_rd[l] = '0; end
    cycles = 0;
    @(negedge clk);
    forever begin
      bit any;
      req_valid = 0;
      any = 0;
      for (int l = 0; l < NL; l++) any |= pend[l];
      chk(stall == any, tag, "stall", stall, any);
      chk(done == exp_mask, tag, "done mask", done, exp_mask);
      for (int l = 0; l < NL; l++)
        if (exp_mask[l] && !we)
          chk(rdata[l*DW +: DW] == exp_rd[l], tag, $sformatf("rd_data lane %0d", l),
              rdata[l*DW +: DW], exp_rd[l]);
      if (!any) break;
      cycles++;
      for (int b = 0; b < NB; b++) taken[b] = -1;
      for (int l = 0; l < NL; l++) begin
        served[l] = 0;
        if (pend[l]) begin
          if (taken[a_addr[l] % NB] < 0) taken[a_addr[l] % NB] = a_addr[l];
          if (taken[a_addr[l] % NB] == a_addr[l]) served[l] = 1;
        end
      end
      for (int l = 0; l < NL; l++) begin
        exp_mask[l] = served[l];
        if (served[l]) begin
          if (we) mdl[a_addr[l]] = a_wd[l];
          else exp_rd[l] = mdl[a_addr[l]];
          pend[l] = 0;
        end
      end
      if (junk && cycles == 1) begin
        req_valid = 1;
        req_we = 1;
        for (int l = 0; l < NL; l++) begin
          lane_en[l] = 1;
          lane_addr[l*AW +: AW] = AW'(900 + l);
          lane_wdata[l*DW +: DW] = 32'hDEAD_0000 + l;
        end
      end
      @(negedge clk);
    end
    if (exp_cycles >= 0)
      chk(cycles == exp_cycles, tag, "stall cycles", cycles, exp_cycles);
  endtask

  task automatic set_all(input int stride, input int base, input logic [31:0] dbase);
    for (int l = 0; l < NL; l++) begin
      a_en[l] = 1;
      a_addr[l] = (base + stride * l) % WORDS;
      a_wd[l] = dbase + l;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < WORDS; w++) mdl[w] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(stall == 0, "R10", "stall at reset", stall, 0);
    chk(done == '0, "R10", "done at reset", done, 0);
    chk(rdata == '0, "R10", "rd_data at reset", rdata[31:0], 0);
    rst_n = 1;
    @(negedge clk);
    chk(stall == 0, "R3", "idle stall", stall, 0);

    // R10 memory cleared: read a stride-1 block before any write
    set_all(1, 500, 0);
    run_req(0, "R10", 1, 0);

    // R1 R3 stride-1 write then read, conflict-free
    set_all(1, 0, 32'hA000_0000);
    run_req(1, "R3", 1, 0);
    set_all(1, 0, 0);
    run_req(0, "R1", 1, 0);

    // R4 stride-2 write gives 2 cycles
    set_all(2, 0, 32'hB000_0000);
    run_req(1, "R4", 2, 0);
    set_all(1, 0, 0);
    run_req(0, "R8", 1, 0);

    // R4 stride-32 gives 32 cycles
    set_all(32, 3, 32'hC000_0000);
    run_req(1, "R4", 32, 0);
    run_req(0, "R4", 32, 0);

    // R5 broadcast read
    set_all(0, 35, 0);
    run_req(0, "R5", 1, 0);

    // R11 stride-33 column access
    set_all(33, 0, 32'hD000_0000);
    run_req(1, "R11", 1, 0);
    run_req(0, "R11", 1, 0);

    // R8 same-address write, highest lane kept
    set_all(0, 100, 32'hE000_0000);
    run_req(1, "R8", 1, 0);
    run_req(0, "R8", 1, 0);
    chk(rdata[0 +: DW] == 32'hE000_001F, "R8", "dup write winner", rdata[0 +: DW], 32'hE000_001F);

    // R6 lowest lane picks row within bank 0
    for (int l = 0; l < NL; l++) begin a_en[l] = 0; a_addr[l] = 0; a_wd[l] = '0; end
    a_en[2] = 1; a_addr[2] = 32;
    a_en[4] = 1; a_addr[4] = 96;
    a_en[7] = 1; a_addr[7] = 96;
    a_en[9] = 1; a_addr[9] = 32;
    a_en[12] = 1; a_addr[12] = 64;
    run_req(0, "R6", 3, 0);

    // R9 partial enable and empty request
    set_all(32, 1, 32'hF000_0000);
    for (int l = 0; l < NL; l += 2) a_en[l] = 0;
    run_req(1, "R9", 16, 0);
    for (int l = 0; l < NL; l++) a_en[l] = 0;
    run_req(0, "R9", 0, 0);

    // R2 request during stall is ignored
    set_all(2, 0, 0);
    run_req(0, "R2", 2, 1);
    set_all(1, 900, 0);
    run_req(0, "R2", 1, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule